// File: doc/BRIEF.md
# Atomic-Alias Control Register Bank

This block is the register file that sits between a simple 32-bit bus and the datapath of a serial peripheral. It holds five general control words, an interrupt word that combines enable bits and pending-cause bits, a data holding word, a pass-through status word and a constant identification word. Every control word and the interrupt word can be reached at four consecutive word addresses. The first is a plain read/write. The other three change only the bits written as one: one address sets them, one clears them and one inverts them. Software can therefore flip single bits without a read-modify-write sequence.

The first control word carries two special bits: a soft reset (bit 31) and a clock gate (bit 30). They are interlocked. While soft reset is held, the gate is held as well and the rest of the bank stays at its reset values. The gate can only be released after soft reset has already been released. Four one-cycle event inputs raise pending causes in the interrupt word. One output reports whether any enabled cause is pending.

The bus address is a word address, so word address = byte offset / 4. The upper bits select the register (byte offset / 0x10). The two lowest bits select the access kind: 0 plain, 1 set, 2 clear, 3 invert. Writes take effect at the clock edge. Read data is combinational from the current address.

Top module: `atomic_csr_bank`

## Requirements
- R1: For the five control words at byte offsets 0x00, 0x10, 0x20, 0x30 and 0x40, a write at the base replaces the word. A write at base+0x4 ORs in the written ones, base+0x8 removes them, and base+0xC inverts them. No other bit changes.
- R2: A read at any of the four addresses of a register returns the base value. Unmapped registers (byte 0x80 and 0xA0 upward) read zero, and writing them changes no register.
- R3: The status word at 0x70 reads the status input. The identification word at 0x90 reads major in [31:24], minor in [23:16] and step in [15:0]. Writes at any of their four addresses have no effect. The data word at 0x60 is plain read/write at its base only; writes at 0x64, 0x68 and 0x6C are ignored.
- R4: After hardware reset, control word 0 reads 0xC000_0000, every other register reads zero and the interrupt output is low.
- R5: While bit 31 of control word 0 is one, control word 0 reads 0xC000_0000. Control words 1 to 4, the data word and the interrupt word read zero and ignore writes. Asserting bit 31 through any address of control word 0 returns them to zero in the next cycle.
- R6: Bit 30 of control word 0 can only be cleared by a write made while bit 31 was already zero. A clear of both bits in one write leaves 0x4000_0000.
- R7: The interrupt word holds enables at bits 22 (receive timeout), 21 (transmit), 20 (receive) and 17 (modem-line change), and the matching pending bits at 6, 5, 4 and 1. All other bits read zero. Event input bit 0 is the line change, bit 1 receive, bit 2 transmit and bit 3 receive timeout.
- R8: An event pulse sets its pending bit at the next edge, unless bit 31 or bit 30 of control word 0 is one. In that case the pulse is ignored.
- R9: A clear-alias write to the interrupt word acknowledges exactly the pending bits written as one and leaves the other pending bits untouched.
- R10: When an event and a clear of the same pending bit fall in one cycle, the bit ends up set.
- R11: The interrupt output is high exactly when some cause has both its pending and its enable bit set. It follows register changes in the cycle after the write or event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Word address (byte offset / 4) |
| we_i | input | 1 | Write strobe for the current address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the current address |
| status_i | input | 32 | Live status word from the datapath |
| evt_i | input | 4 | One-cycle interrupt cause pulses |
| ctl_o | output | 5x32 | Current control words 0 to 4 |
| data_o | output | 32 | Current data holding word |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Two of the block's functions can land in the same cycle: a cause event raising a pending bit, and a clear-alias write acknowledging that same bit. The bench provokes this by driving an event pulse in the same cycle as a write to the interrupt clear address. The written mask covers both the colliding bit and a second pending bit. The result is judged by reading the interrupt word afterwards. The colliding bit must remain set while the other bit is cleared, and the interrupt output must track the outcome once the matching enable is set.

// File: rtl/csr_pkg.sv
package csr_pkg;

    localparam int unsigned WORD_W    = 32;
    localparam int unsigned NUM_CTL   = 5;
    localparam int unsigned NUM_CAUSE = 4;

    localparam int unsigned SRST_BIT = 31;
    localparam int unsigned GATE_BIT = 30;

    localparam logic [WORD_W-1:0] CTL0_RST = 32'hC000_0000;

    // register slots (byte offset / 0x10)
    localparam int unsigned REG_IRQ  = 5;
    localparam int unsigned REG_DATA = 6;
    localparam int unsigned REG_STAT = 7;
    localparam int unsigned REG_VER  = 9;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_SET   = 2'd1,
        OP_CLEAR = 2'd2,
        OP_FLIP  = 2'd3
    } alias_op_e;

    // cause order: 0 line change, 1 receive, 2 transmit, 3 receive timeout
    function automatic int unsigned stat_pos(input int unsigned k);
        case (k)
            0:       return 1;
            1:       return 4;
            2:       return 5;
            default: return 6;
        endcase
    endfunction

    function automatic int unsigned ena_pos(input int unsigned k);
        case (k)
            0:       return 17;
            1:       return 20;
            2:       return 21;
            default: return 22;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] irq_mask();
        logic [WORD_W-1:0] m;
        m = '0;
        for (int unsigned k = 0; k < NUM_CAUSE; k++) begin
            m[stat_pos(k)] = 1'b1;
            m[ena_pos(k)]  = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/csr_alias_apply.sv
module csr_alias_apply
    import csr_pkg::*;
#(
    parameter logic [WORD_W-1:0] MASK = '1
) (
    input  logic [WORD_W-1:0] old_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  alias_op_e         op_i,
    input  logic              en_i,
    output logic [WORD_W-1:0] new_o
);

    logic [WORD_W-1:0] hit;
    assign hit = wdata_i & MASK;

    always_comb begin
        new_o = old_i;
        if (en_i) begin
            unique case (op_i)
                OP_WRITE: new_o = (old_i & ~MASK) | hit;
                OP_SET:   new_o = old_i | hit;
                OP_CLEAR: new_o = old_i & ~hit;
                OP_FLIP:  new_o = old_i ^ hit;
            endcase
        end
    end

endmodule

// File: rtl/csr_irq_unit.sv
module csr_irq_unit
    import csr_pkg::*;
(
    input  logic [WORD_W-1:0]    cur_i,
    input  logic                 wr_i,
    input  alias_op_e            op_i,
    input  logic [WORD_W-1:0]    wdata_i,
    input  logic [NUM_CAUSE-1:0] evt_i,
    input  logic                 capture_i,
    output logic [WORD_W-1:0]    nxt_o,
    output logic                 irq_o
);

    localparam logic [WORD_W-1:0] IRQ_MASK = irq_mask();

    logic [WORD_W-1:0]    after_bus;
    logic [WORD_W-1:0]    evt_bits;
    logic [NUM_CAUSE-1:0] pend;

    csr_alias_apply #(.MASK(IRQ_MASK)) u_irq_apply (
        .old_i   (cur_i),
        .wdata_i (wdata_i),
        .op_i    (op_i),
        .en_i    (wr_i),
        .new_o   (after_bus)
    );

    always_comb begin
        evt_bits = '0;
        pend     = '0;
        for (int unsigned k = 0; k < NUM_CAUSE; k++) begin
            evt_bits[stat_pos(k)] = evt_i[k] & capture_i;
            pend[k] = cur_i[stat_pos(k)] & cur_i[ena_pos(k)];
        end
    end

    // an event in the same cycle as a clear keeps the bit set
    assign nxt_o = after_bus | evt_bits;
    assign irq_o = |pend;

endmodule

// File: rtl/csr_read_mux.sv
module csr_read_mux
    import csr_pkg::*;
#(
    parameter int unsigned IDX_W = 4
) (
    input  logic [IDX_W-1:0]              idx_i,
    input  logic [NUM_CTL-1:0][WORD_W-1:0] ctl_i,
    input  logic [WORD_W-1:0]             irq_i,
    input  logic [WORD_W-1:0]             data_i,
    input  logic [WORD_W-1:0]             stat_i,
    input  logic [WORD_W-1:0]             ver_i,
    output logic [WORD_W-1:0]             rdata_o
);

    always_comb begin
        rdata_o = '0;
        for (int unsigned k = 0; k < NUM_CTL; k++) begin
            if (idx_i == IDX_W'(k)) rdata_o = ctl_i[k];
        end
        if (idx_i == IDX_W'(REG_IRQ))  rdata_o = irq_i;
        if (idx_i == IDX_W'(REG_DATA)) rdata_o = data_i;
        if (idx_i == IDX_W'(REG_STAT)) rdata_o = stat_i;
        if (idx_i == IDX_W'(REG_VER))  rdata_o = ver_i;
    end

endmodule

// File: rtl/atomic_csr_bank.sv
module atomic_csr_bank
    import csr_pkg::*;
#(
    parameter int unsigned ADDR_W    = 6,
    parameter logic [7:0]  VER_MAJOR = 8'd1,
    parameter logic [7:0]  VER_MINOR = 8'd4,
    parameter logic [15:0] VER_STEP  = 16'd2
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic [ADDR_W-1:0]              addr_i,
    input  logic                           we_i,
    input  logic [WORD_W-1:0]              wdata_i,
    output logic [WORD_W-1:0]              rdata_o,
    input  logic [WORD_W-1:0]              status_i,
    input  logic [NUM_CAUSE-1:0]           evt_i,
    output logic [NUM_CTL-1:0][WORD_W-1:0] ctl_o,
    output logic [WORD_W-1:0]              data_o,
    output logic                           irq_o
);

    localparam int unsigned       IDX_W    = ADDR_W - 2;
    localparam logic [WORD_W-1:0] VER_WORD = {VER_MAJOR, VER_MINOR, VER_STEP};

    typedef struct packed {
        logic [NUM_CTL-1:0][WORD_W-1:0] ctl;
        logic [WORD_W-1:0]              irq;
        logic [WORD_W-1:0]              data;
    } bank_t;

    bank_t bank_d, bank_q;

    logic [IDX_W-1:0]               idx;
    alias_op_e                      op;
    logic [NUM_CTL-1:0][WORD_W-1:0] ctl_upd;
    logic [WORD_W-1:0]              irq_q;
    logic [WORD_W-1:0]              irq_upd;
    logic [WORD_W-1:0]              c0;
    logic                           srst_q;
    logic                           gate_q;

    assign idx    = addr_i[ADDR_W-1:2];
    assign op     = alias_op_e'(addr_i[1:0]);
    assign irq_q  = bank_q.irq;
    assign srst_q = bank_q.ctl[0][SRST_BIT];
    assign gate_q = bank_q.ctl[0][GATE_BIT];

    for (genvar g = 0; g < NUM_CTL; g++) begin : g_ctl
        csr_alias_apply #(.MASK('1)) u_ctl_apply (
            .old_i   (bank_q.ctl[g]),
            .wdata_i (wdata_i),
            .op_i    (op),
            .en_i    (we_i && (idx == IDX_W'(g))),
            .new_o   (ctl_upd[g])
        );
    end

    csr_irq_unit u_irq (
        .cur_i     (irq_q),
        .wr_i      (we_i && (idx == IDX_W'(REG_IRQ))),
        .op_i      (op),
        .wdata_i   (wdata_i),
        .evt_i     (evt_i),
        .capture_i (!srst_q && !gate_q),
        .nxt_o     (irq_upd),
        .irq_o     (irq_o)
    );

    csr_read_mux #(.IDX_W(IDX_W)) u_rd (
        .idx_i   (idx),
        .ctl_i   (bank_q.ctl),
        .irq_i   (bank_q.irq),
        .data_i  (bank_q.data),
        .stat_i  (status_i),
        .ver_i   (VER_WORD),
        .rdata_o (rdata_o)
    );

    always_comb begin
        bank_d = bank_q;

        // soft reset / clock gate interlock
        c0 = ctl_upd[0];
        if (srst_q) c0[GATE_BIT] = 1'b1;
        if (c0[SRST_BIT]) c0 = CTL0_RST;
        bank_d.ctl[0] = c0;

        if (c0[SRST_BIT]) begin
            for (int unsigned k = 1; k < NUM_CTL; k++) bank_d.ctl[k] = '0;
            bank_d.irq  = '0;
            bank_d.data = '0;
        end else begin
            for (int unsigned k = 1; k < NUM_CTL; k++) bank_d.ctl[k] = ctl_upd[k];
            bank_d.irq = irq_upd;
            if (we_i && (idx == IDX_W'(REG_DATA)) && (op == OP_WRITE))
                bank_d.data = wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            bank_q        <= '0;
            bank_q.ctl[0] <= CTL0_RST;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign ctl_o  = bank_q.ctl;
    assign data_o = bank_q.data;

endmodule

// File: rtl/csr_bank_checker.sv
module csr_bank_checker
    import csr_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input logic                           clk_i,
    input logic                           rst_ni,
    input logic [ADDR_W-1:0]              addr_i,
    input logic                           we_i,
    input logic [WORD_W-1:0]              wdata_i,
    input logic [NUM_CAUSE-1:0]           evt_i,
    input logic [NUM_CTL-1:0][WORD_W-1:0] ctl_i,
    input logic [WORD_W-1:0]              irq_reg_i
);

    localparam int unsigned IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic [1:0]       op;
    logic             others_zero;

    assign idx = addr_i[ADDR_W-1:2];
    assign op  = addr_i[1:0];

    always_comb begin
        others_zero = (irq_reg_i == '0);
        for (int unsigned k = 1; k < NUM_CTL; k++)
            if (ctl_i[k] != '0) others_zero = 1'b0;
    end

    AST_GATE_HELD_IN_SRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctl_i[0][SRST_BIT] |-> ctl_i[0][GATE_BIT]) else $error("gate low in soft reset"); // R6

    AST_GATE_AFTER_SRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(ctl_i[0][GATE_BIT]) |-> !$past(ctl_i[0][SRST_BIT])) else $error("gate fell with reset"); // R6

    AST_SRST_ZEROES_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctl_i[0][SRST_BIT] |-> others_zero) else $error("bank not cleared in soft reset"); // R5

    AST_RO_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && ((idx == IDX_W'(REG_STAT)) || (idx == IDX_W'(REG_VER)))) |=> $stable(ctl_i)) else $error("read-only write changed controls"); // R3

    AST_CLR_KEEPS_OTHERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && (idx == IDX_W'(REG_IRQ)) && (op == 2'd2) && (evt_i == '0) && !ctl_i[0][SRST_BIT])
        |=> ((irq_reg_i & ~$past(wdata_i)) == ($past(irq_reg_i) & ~$past(wdata_i)))) else $error("clear touched other bits"); // R9

    for (genvar g = 0; g < NUM_CAUSE; g++) begin : g_evt
        localparam int unsigned SP = stat_pos(g);
        AST_EVT_SETS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (evt_i[g] && (ctl_i[0][SRST_BIT:GATE_BIT] == 2'b00) && !(we_i && (idx == '0)))
            |=> irq_reg_i[SP]) else $error("event not captured"); // R8
    end

endmodule

bind atomic_csr_bank csr_bank_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .we_i      (we_i),
    .wdata_i   (wdata_i),
    .evt_i     (evt_i),
    .ctl_i     (ctl_o),
    .irq_reg_i (irq_q)
);

// File: tb/test_atomic_csr_bank.sv
module test_atomic_csr_bank;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [5:0]       addr = '0;
    logic             we = 1'b0;
    logic [31:0]      wdata = '0;
    logic [31:0]      rdata;
    logic [31:0]      status = '0;
    logic [3:0]       evt = '0;
    logic [4:0][31:0] ctl;
    logic [31:0]      data;
    logic             irq;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    atomic_csr_bank i_atomic_csr_bank (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .addr_i   (addr),
        .we_i     (we),
        .wdata_i  (wdata),
        .rdata_o  (rdata),
        .status_i (status),
        .evt_i    (evt),
        .ctl_o    (ctl),
        .data_o   (data),
        .irq_o    (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] boff, input logic [31:0] val);
        @(negedge clk);
        addr = boff[7:2]; we = 1'b1; wdata = val;
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic wr_evt(input logic [7:0] boff, input logic [31:0] val, input logic [3:0] e);
        @(negedge clk);
        addr = boff[7:2]; we = 1'b1; wdata = val; evt = e;
        @(negedge clk);
        we = 1'b0; wdata = '0; evt = '0;
    endtask

    task automatic pulse(input logic [3:0] e);
        @(negedge clk);
        evt = e;
        @(negedge clk);
        evt = '0;
    endtask

    task automatic rd_check(input string req, input logic [7:0] boff, input logic [31:0] exp);
        @(negedge clk);
        addr = boff[7:2]; we = 1'b0;
        #1;
        check(req, rdata, exp);
    endtask

    task automatic irq_check(input string req, input logic exp);
        @(negedge clk);
        #1;
        check(req, {31'd0, irq}, {31'd0, exp});
    endtask

    task automatic t_reset;
        rd_check("R4 ctl0 reset", 8'h00, 32'hC000_0000);
        rd_check("R4 ctl1 reset", 8'h10, 32'h0);
        rd_check("R4 irq reset", 8'h50, 32'h0);
        irq_check("R4 irq_o reset", 1'b0);
    endtask

    task automatic t_soft_reset_hold;
        wr(8'h10, 32'h0000_1234);
        rd_check("R5 ctl1 ignores write", 8'h10, 32'h0);
        wr(8'h00, 32'hFFFF_FFFF);
        rd_check("R5 ctl0 pinned", 8'h00, 32'hC000_0000);
        pulse(4'hF);
        rd_check("R8 event ignored in reset", 8'h50, 32'h0);
    endtask

    task automatic t_interlock;
        wr(8'h08, 32'hC000_0000);
        rd_check("R6 gate kept on joint clear", 8'h00, 32'h4000_0000);
        wr(8'h08, 32'h4000_0000);
        rd_check("R6 gate released", 8'h00, 32'h0);
    endtask

    task automatic t_alias;
        wr(8'h20, 32'h0000_F0F0);
        rd_check("R1 plain write", 8'h20, 32'h0000_F0F0);
        wr(8'h24, 32'h0F00_000F);
        rd_check("R1 set alias", 8'h20, 32'h0F00_F0FF);
        wr(8'h28, 32'h0000_00F0);
        rd_check("R1 clear alias", 8'h20, 32'h0F00_F00F);
        wr(8'h2C, 32'hFF00_0001);
        rd_check("R1 toggle alias", 8'h20, 32'hF000_F00E);
        @(negedge clk);
        check("R1 ctl_o word 2", ctl[2], 32'hF000_F00E);
        wr(8'h44, 32'h8000_0001);
        rd_check("R1 set on word 4", 8'h40, 32'h8000_0001);
        check("R1 word 1 untouched", ctl[1], 32'h0);
    endtask

    task automatic t_alias_read;
        rd_check("R2 read at +4", 8'h24, 32'hF000_F00E);
        rd_check("R2 read at +8", 8'h28, 32'hF000_F00E);
        rd_check("R2 read at +C", 8'h2C, 32'hF000_F00E);
        wr(8'h80, 32'hFFFF_FFFF);
        wr(8'hA4, 32'hFFFF_FFFF);
        rd_check("R2 unmapped 0x80", 8'h80, 32'h0);
        rd_check("R2 unmapped 0xA0", 8'hA0, 32'h0);
        rd_check("R2 no side effect", 8'h20, 32'hF000_F00E);
    endtask

    task automatic t_readonly;
        status = 32'hA5A5_0003;
        rd_check("R3 status read", 8'h70, 32'hA5A5_0003);
        rd_check("R3 status alias read", 8'h7C, 32'hA5A5_0003);
        wr(8'h74, 32'hFFFF_FFFF);
        wr(8'h9C, 32'hFFFF_FFFF);
        rd_check("R3 version", 8'h90, 32'h0104_0002);
        rd_check("R3 status unchanged", 8'h70, 32'hA5A5_0003);
        wr(8'h60, 32'hDEAD_BEEF);
        rd_check("R3 data write", 8'h60, 32'hDEAD_BEEF);
        wr(8'h64, 32'h0000_FFFF);
        rd_check("R3 data alias write ignored", 8'h60, 32'hDEAD_BEEF);
    endtask

    task automatic t_irq_layout;
        wr(8'h50, 32'hFFFF_FFFF);
        rd_check("R7 only defined bits", 8'h50, 32'h0072_0072);
        irq_check("R11 irq high all set", 1'b1);
        wr(8'h58, 32'hFFFF_FFFF);
        rd_check("R9 clear all", 8'h50, 32'h0);
        irq_check("R11 irq low after ack", 1'b0);
    endtask

    task automatic t_irq_events;
        wr(8'h54, 32'h0072_0000);
        irq_check("R11 enables alone", 1'b0);
        pulse(4'b0100);
        rd_check("R8 tx event bit 5", 8'h50, 32'h0072_0020);
        irq_check("R11 irq on tx", 1'b1);
        wr(8'h04, 32'h4000_0000);
        pulse(4'b0001);
        rd_check("R8 event ignored while gated", 8'h50, 32'h0072_0020);
        wr(8'h08, 32'h4000_0000);
        rd_check("R6 gate cleared", 8'h00, 32'h0);
    endtask

    task automatic t_irq_ack;
        pulse(4'hF);
        rd_check("R7 all causes pending", 8'h50, 32'h0072_0072);
        wr(8'h58, 32'h0000_0020);
        rd_check("R9 ack tx only", 8'h50, 32'h0072_0052);
        wr(8'h58, 32'h0000_0010);
        rd_check("R9 ack rx only", 8'h50, 32'h0072_0042);
    endtask

    task automatic t_set_wins;
        wr_evt(8'h58, 32'h0000_0012, 4'b0010);
        rd_check("R10 event beats clear", 8'h50, 32'h0072_0050);
    endtask

    task automatic t_irq_mask;
        wr(8'h58, 32'h0072_0000);
        rd_check("R11 enables cleared", 8'h50, 32'h0000_0050);
        irq_check("R11 pending but disabled", 1'b0);
        wr(8'h54, 32'h0010_0000);
        irq_check("R11 rx enable", 1'b1);
    endtask

    task automatic t_reassert;
        wr(8'h30, 32'h0000_0055);
        wr(8'h60, 32'h0000_0077);
        wr(8'h0C, 32'h8000_0000);
        rd_check("R5 ctl0 after toggle", 8'h00, 32'hC000_0000);
        rd_check("R5 ctl3 zeroed", 8'h30, 32'h0);
        rd_check("R5 data zeroed", 8'h60, 32'h0);
        rd_check("R5 irq zeroed", 8'h50, 32'h0);
        irq_check("R5 irq_o low", 1'b0);
        wr(8'h30, 32'h0000_0055);
        rd_check("R5 write ignored", 8'h30, 32'h0);
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_soft_reset_hold();
        t_interlock();
        t_alias();
        t_alias_read();
        t_readonly();
        t_irq_layout();
        t_irq_events();
        t_irq_ack();
        t_set_wins();
        t_irq_mask();
        t_reassert();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog all actual=running expected=finished");
            summary();
            $finish;
        end
    end

endmodule